// File: doc/BRIEF.md
# Carry-Pulse Phase Accumulator

This block is a phase accumulator. It adds a frequency word into a phase register on every rising clock edge. The carry out of the top bit of that addition is registered and drives a single output pin. A frequency word F on a W-bit phase therefore gives an average pulse rate of F / 2^W of the clock. Each pulse is one clock wide, so the pin is suited to duty-cycle and sigma-delta style output.

A processor core reaches the block through two independent write strobes, one for the phase register and one for the frequency register, and it can read the phase register. A phase write replaces that edge's accumulation and does not add to it. Software can therefore preset the phase and know the exact edge of the first pulse. A frequency write changes nothing on its own edge and is used from the edge after.

Top module: `duty_accum`

## Requirements
- R1: After reset the phase register and the frequency register both hold zero and `pulse_out` is low. With no writes, the phase stays at zero and the pin stays low.
- R2: On each rising edge without a phase write, the phase becomes (phase + frequency) modulo 2^W.
- R3: On an edge with `phase_we` high, the phase takes `phase_wdata` in place of the sum. `pulse_out` is then low for the following clock, even if the discarded sum would have wrapped.
- R4: `pulse_out` is high for exactly the one clock that follows an accumulating edge whose unsigned sum exceeded 2^W - 1. It is low after every other edge.
- R5: A frequency written on edge k has no effect on the phase update at edge k and is used from edge k+1 on.
- R6: When both registers are written on the same edge, the phase takes the written value and the new frequency is added from the next edge.
- R7: With the phase preset to 0xF0000000 and a frequency of 0x08000000, the first accumulating edge gives 0xF8000000 with the pin low. The second gives 0x00000000 with the pin high.
- R8: With the frequency at its maximum of 0xFFFFFFFF, every accumulating edge from a non-zero phase decrements the phase and pulses the pin. An edge from a zero phase wraps to 0xFFFFFFFF with the pin low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_we | input | 1 | Phase register write strobe |
| phase_wdata | input | W (32) | Value loaded into the phase register |
| freq_we | input | 1 | Frequency register write strobe |
| freq_wdata | input | W (32) | Value loaded into the frequency register |
| phase_rd | output | W (32) | Current phase register contents |
| pulse_out | output | 1 | Registered carry pulse, one clock wide |

## Verification
The checker assumes that both write strobes and their data are known, driven synchronously, and stable around each rising edge. It also assumes that a strobe held high for several clocks means one write per edge. The bench changes every input only on the falling edge and keeps the strobes at 0 or 1 through reset. A reference adder in the bench predicts the phase and carry for each edge, and the bench compares the design against it half a clock later.

// File: rtl/duty_acc_pkg.sv
package duty_acc_pkg;

  // Which value the phase flip-flops capture on the coming edge.
  typedef enum logic {
    PH_SRC_SUM  = 1'b0,
    PH_SRC_LOAD = 1'b1
  } phase_src_e;

  localparam int unsigned DEFAULT_W = 32;

endpackage

// File: rtl/duty_freq_reg.sv
module duty_freq_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] freq_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  freq_q <= '0;
    else if (we) freq_q <= wdata;
  end

endmodule

// File: rtl/duty_phase_adder.sv
module duty_phase_adder #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] phase,
  input  logic [W-1:0] freq,
  output logic [W-1:0] sum,
  output logic         wrap
);

  localparam int unsigned SW = W + 1;

  // Returns {carry, sum} of an unsigned W-bit add.
  function automatic logic [SW-1:0] add_wide(input logic [W-1:0] a, input logic [W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  logic [SW-1:0] full;

  always_comb begin
    full = add_wide(phase, freq);
    sum  = full[W-1:0];
    wrap = full[W];
  end

endmodule

// File: rtl/duty_phase_reg.sv
module duty_phase_reg
  import duty_acc_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  phase_src_e   src,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] sum,
  input  logic         wrap,
  output logic [W-1:0] phase_q,
  output logic         pulse_q
);

  logic [W-1:0] phase_d;
  logic         pulse_d;

  always_comb begin
    unique case (src)
      PH_SRC_LOAD: begin
        phase_d = load_val;
        pulse_d = 1'b0;
      end
      default: begin
        phase_d = sum;
        pulse_d = wrap;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      pulse_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      pulse_q <= pulse_d;
    end
  end

endmodule

// File: rtl/duty_accum.sv
module duty_accum
  import duty_acc_pkg::*;
#(
  parameter int unsigned W = DEFAULT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         phase_we,
  input  logic [W-1:0] phase_wdata,
  input  logic         freq_we,
  input  logic [W-1:0] freq_wdata,
  output logic [W-1:0] phase_rd,
  output logic         pulse_out
);

  logic [W-1:0] freq_q;
  logic [W-1:0] acc_sum;
  logic         acc_wrap;
  phase_src_e   ph_src;

  assign ph_src = phase_we ? PH_SRC_LOAD : PH_SRC_SUM;

  duty_freq_reg #(.W(W)) u_freq (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (freq_we),
    .wdata  (freq_wdata),
    .freq_q (freq_q)
  );

  duty_phase_adder #(.W(W)) u_add (
    .phase (phase_rd),
    .freq  (freq_q),
    .sum   (acc_sum),
    .wrap  (acc_wrap)
  );

  duty_phase_reg #(.W(W)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .src      (ph_src),
    .load_val (phase_wdata),
    .sum      (acc_sum),
    .wrap     (acc_wrap),
    .phase_q  (phase_rd),
    .pulse_q  (pulse_out)
  );

endmodule

// File: rtl/duty_accum_chk.sv
module duty_accum_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         phase_we,
  input logic [W-1:0] phase_wdata,
  input logic         freq_we,
  input logic [W-1:0] freq_wdata,
  input logic [W-1:0] phase_rd,
  input logic         pulse_out,
  input logic [W-1:0] freq_q,
  input logic         acc_wrap
);

  AST_PHASE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    phase_we |=> phase_rd == $past(phase_wdata)); // R3

  AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    phase_we |=> !pulse_out); // R3

  AST_ACCUM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !phase_we |=> (phase_rd - $past(phase_rd)) == $past(freq_q)); // R2

  AST_WRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase_we && acc_wrap) |=> pulse_out); // R4

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_wrap |=> !pulse_out); // R4

  AST_FREQ_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    freq_we |=> freq_q == $past(freq_wdata)); // R5

  AST_FREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !freq_we |=> $stable(freq_q)); // R5

endmodule

bind duty_accum duty_accum_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .phase_we    (phase_we),
  .phase_wdata (phase_wdata),
  .freq_we     (freq_we),
  .freq_wdata  (freq_wdata),
  .phase_rd    (phase_rd),
  .pulse_out   (pulse_out),
  .freq_q      (freq_q),
  .acc_wrap    (acc_wrap)
);

// File: tb/duty_accum_tb.sv
`timescale 1ns/1ps
module duty_accum_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        phase_we = 1'b0;
  logic [31:0] phase_wdata = '0;
  logic        freq_we = 1'b0;
  logic [31:0] freq_wdata = '0;
  logic [31:0] phase_rd;
  logic        pulse_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [31:0] ph;
    logic        pl;
    string       tag;
  } exp_t;
  exp_t sb[$];

  logic [31:0] m_ph = '0;
  logic [31:0] m_fr = '0;
  logic        m_pl = 1'b0;

  always #5 clk = ~clk;

  duty_accum u_dut (
    .clk(clk), .rst_n(rst_n),
    .phase_we(phase_we), .phase_wdata(phase_wdata),
    .freq_we(freq_we), .freq_wdata(freq_wdata),
    .phase_rd(phase_rd), .pulse_out(pulse_out)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] aph, input logic apl,
                       input logic [31:0] eph, input logic epl);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: phase=%h pulse=%b expected phase=%h pulse=%b", tag, aph, apl, eph, epl);
    end
  endtask

  // Driver: applies one edge of stimulus, advances the reference model, queues the result.
  task automatic drive(input bit pw, input logic [31:0] pd, input bit fw, input logic [31:0] fd,
                       input string tag);
    logic [31:0] nxt;
    exp_t e;
    phase_we = pw; phase_wdata = pd; freq_we = fw; freq_wdata = fd;
    @(posedge clk);
    if (pw) begin
      m_ph = pd;
      m_pl = 1'b0;
    end else begin
      nxt  = m_ph + m_fr;
      m_pl = (nxt < m_ph);   // unsigned wrap shows as a smaller result
      m_ph = nxt;
    end
    if (fw) m_fr = fd;
    e.ph = m_ph; e.pl = m_pl; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    phase_we = 1'b0; freq_we = 1'b0;
  endtask

  task automatic idle(input string tag);
    drive(1'b0, '0, 1'b0, '0, tag);
  endtask

  // Monitor: compares half a clock after each edge.
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(phase_rd === e.ph && pulse_out === e.pl, e.tag, phase_rd, pulse_out, e.ph, e.pl);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(phase_rd === '0 && pulse_out === 1'b0, "R1", phase_rd, pulse_out, '0, 1'b0);
    rst_n = 1'b1;
    repeat (3) idle("R1");

    // R5: new frequency unused on its own edge
    drive(1'b0, '0, 1'b1, 32'd5, "R5");
    idle("R5");
    idle("R2");
    drive(1'b0, '0, 1'b1, 32'h1000_0000, "R5");
    idle("R2");

    // R6 + R7: preset and frequency on the same edge, first pulse on second edge
    drive(1'b1, 32'hF000_0000, 1'b1, 32'h0800_0000, "R6");
    idle("R7");
    idle("R7");
    idle("R4");

    // R3: load on an edge whose sum would have wrapped
    drive(1'b1, 32'hFFFF_FFFF, 1'b0, '0, "R3");
    drive(1'b1, 32'h0000_0010, 1'b0, '0, "R3");
    idle("R2");

    // R8: maximum frequency
    drive(1'b1, 32'd3, 1'b1, 32'hFFFF_FFFF, "R6");
    repeat (5) idle("R8");

    // R2/R4: random presets and frequency words
    for (int i = 0; i < 400; i++) begin
      bit pw, fw;
      pw = ($urandom_range(0, 9) == 0);
      fw = ($urandom_range(0, 11) == 0);
      drive(pw, $urandom(), fw, (($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom()), "R2");
    end

    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule